// File: doc/BRIEF.md
# Vertical Six-Tap Luma Interpolator

This block produces vertical half-sample luma predictions for a rectangular block of 8-bit pixels. Source rows arrive whole, one row-vector per cycle, on a valid/ready input stream. The block keeps the five most recent rows in a sliding window. Each new row completes a six-row column stack, and from it the block computes one output row: a symmetric six-tap filter down every column, followed by rounding and saturation to 8 bits. Output rows leave on a second valid/ready stream.

The caller pulses start with a width code and a height code. The block then accepts exactly height + 5 input rows and emits exactly height output rows. After the last output row is taken it raises done for one cycle. Stalls on the output stream hold the window without losing or repeating any row.

Top module: `vsix_interp`

## Requirements
- R1: For every active column, with A..F the six vertically consecutive input pixels (A oldest), the filter sum is (A+F) + 20*(C+D) - 5*(B+E), computed without wrap-around.
- R2: The output pixel is (sum + 16) >> 5, using an arithmetic shift.
- R3: A negative result outputs 0. A result above 255 outputs 255.
- R4: Output row r is built from input rows r..r+5 of the block. No output row is offered before the sixth input row has been accepted.
- R5: Width code 0/1/2 selects 4/8/16 active lanes, and code 3 acts as 16. Lane i sits at bits [8i+7:8i] of both row buses. Lanes at or above the active count output 0.
- R6: Height code 0/1/2 selects 4/8/16 output rows, and code 3 acts as 16. Exactly height+5 input rows are accepted per block. After that, inReady stays low until the next start.
- R7: While outValid is high and outReady is low, outValid stays high and outRow keeps its value. No row is lost or duplicated.
- R8: doneOut is high for exactly one cycle: the cycle after the handshake of the final output row.
- R9: After reset, and before any start, inReady, outValid and doneOut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse; it latches the size codes and is taken only while idle |
| widthSel | input | 2 | Width code (0:4, 1:8, 2/3:16 pixels) |
| heightSel | input | 2 | Height code (0:4, 1:8, 2/3:16 rows) |
| inValid | input | 1 | Input row valid |
| inReady | output | 1 | Input row accepted when high together with inValid |
| inRow | input | 128 | Input row, lane i at [8i+7:8i] |
| outValid | output | 1 | Output row valid |
| outReady | input | 1 | Output row taken when high together with outValid |
| outRow | output | 128 | Filtered output row |
| doneOut | output | 1 | One-cycle block-complete pulse |

## Verification
An accepted input row that completes a six-row stack puts its filtered result on outRow one clock after the accepting edge. The done pulse appears one clock after the final output handshake. The bench drives all inputs at the falling edge and settles briefly before judging handshakes, so each handshake is attributed to the rising edge that follows. It then checks outValid, outRow and doneOut at the next falling edge, which is exactly one register stage later. Held rows are compared against the value seen at the previous falling edge whenever the previous cycle was stalled.

// File: rtl/vsix_pkg.sv
package vsix_pkg;
  localparam int PIX_W = 8;

  typedef logic [PIX_W-1:0] pixT;

  // strobes from control to datapath
  typedef struct packed {
    logic winShift;  // accept the input row into the window
    logic outLoad;   // capture the filtered row into the output register
  } ctlT;

  // size code to count: 0->4, 1->8, otherwise 16
  function automatic logic [4:0] sizeFromCode(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // six-tap vertical kernel with rounding and clamping
  function automatic pixT tapFilter(input pixT a, input pixT b, input pixT c,
                                    input pixT d, input pixT e, input pixT f);
    logic signed [15:0] outer;
    logic signed [15:0] inner;
    logic signed [15:0] side;
    logic signed [15:0] acc;
    logic signed [15:0] shifted;
    outer   = $signed({8'd0, a}) + $signed({8'd0, f});
    inner   = $signed({8'd0, c}) + $signed({8'd0, d});
    side    = $signed({8'd0, b}) + $signed({8'd0, e});
    acc     = outer + 16'sd20 * inner - 16'sd5 * side;
    shifted = (acc + 16'sd16) >>> 5;
    if (shifted < 16'sd0)        return '0;
    else if (shifted > 16'sd255) return 8'hFF;
    else                         return shifted[7:0];
  endfunction
endpackage

// File: rtl/vsix_ctrl.sv
module vsix_ctrl
  import vsix_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int MAX_ROWS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [1:0]       widthSel,
  input  logic [1:0]       heightSel,
  input  logic             inValid,
  output logic             inReady,
  input  logic             outReady,
  output logic             outValid,
  output logic             doneOut,
  output ctlT              ctl,
  output logic [LANES-1:0] laneEn
);
  localparam int CNT_W = $clog2(MAX_ROWS + 6);
  localparam int PRIME = 5;  // rows needed before the first output

  logic             active;
  logic [4:0]       lanesQ;
  logic [CNT_W-1:0] rowsQ;
  logic [CNT_W-1:0] inCnt;
  logic [CNT_W-1:0] outCnt;
  logic [CNT_W-1:0] inLimit;
  logic             outValidQ;
  logic             doneQ;
  logic             accept;
  logic             outFire;
  logic             primed;

  assign inLimit = rowsQ + CNT_W'(PRIME);
  assign primed  = (inCnt >= CNT_W'(PRIME));
  assign inReady = active && (inCnt < inLimit) && (!primed || !outValidQ || outReady);
  assign accept  = inValid && inReady;
  assign outFire = outValidQ && outReady;

  assign ctl.winShift = accept;
  assign ctl.outLoad  = accept && primed;

  assign outValid = outValidQ;
  assign doneOut  = doneQ;

  for (genvar g = 0; g < LANES; g++) begin : gLaneEn
    assign laneEn[g] = (g < int'(lanesQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      lanesQ    <= '0;
      rowsQ     <= '0;
      inCnt     <= '0;
      outCnt    <= '0;
      outValidQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!active && startIn) begin
        active <= 1'b1;
        lanesQ <= sizeFromCode(widthSel);
        rowsQ  <= CNT_W'(sizeFromCode(heightSel));
        inCnt  <= '0;
        outCnt <= '0;
      end else begin
        if (accept) inCnt <= inCnt + 1'b1;
        if (ctl.outLoad)  outValidQ <= 1'b1;
        else if (outFire) outValidQ <= 1'b0;
        if (outFire) begin
          outCnt <= outCnt + 1'b1;
          if (outCnt == rowsQ - 1'b1) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end
        end
      end
    end
  end

  // R7: a stalled row stays offered
  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R8: done follows an output handshake
  a_r8_done_after_fire: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> $past(outValid && outReady));

  // R6: a finished block has taken exactly height + 5 rows
  a_r6_row_total: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (inCnt == inLimit) && !inReady);

  // R8: the pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
endmodule

// File: rtl/vsix_datapath.sv
module vsix_datapath
  import vsix_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlT                    ctl,
  input  logic [LANES-1:0]       laneEn,
  input  logic [LANES*PIX_W-1:0] inRow,
  output logic [LANES*PIX_W-1:0] outRow
);
  localparam int TAPS  = 6;
  localparam int DEPTH = TAPS - 1;
  localparam int ROW_W = LANES * PIX_W;

  logic [ROW_W-1:0] win [DEPTH];
  logic [ROW_W-1:0] outQ;
  logic [ROW_W-1:0] filtRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) win[i] <= '0;
    end else if (ctl.winShift) begin
      for (int i = 0; i < DEPTH - 1; i++) win[i] <= win[i+1];
      win[DEPTH-1] <= inRow;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int LO = g * PIX_W;
    pixT pix;
    assign pix = tapFilter(win[0][LO +: PIX_W], win[1][LO +: PIX_W],
                           win[2][LO +: PIX_W], win[3][LO +: PIX_W],
                           win[4][LO +: PIX_W], inRow[LO +: PIX_W]);
    assign filtRow[LO +: PIX_W] = laneEn[g] ? pix : '0;

    // R5: a lane that is switched off outputs zero after a load
    a_r5_lane_off_zero: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctl.outLoad && !laneEn[g]) |-> (outQ[LO +: PIX_W] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outQ <= '0;
    else if (ctl.outLoad) outQ <= filtRow;
  end

  assign outRow = outQ;
endmodule

// File: rtl/vsix_interp.sv
module vsix_interp
  import vsix_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int MAX_ROWS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  input  logic [1:0]             widthSel,
  input  logic [1:0]             heightSel,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [LANES*PIX_W-1:0] inRow,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [LANES*PIX_W-1:0] outRow,
  output logic                   doneOut
);
  ctlT              ctl;
  logic [LANES-1:0] laneEn;

  vsix_ctrl #(.LANES(LANES), .MAX_ROWS(MAX_ROWS)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .widthSel(widthSel),
    .heightSel(heightSel), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .doneOut(doneOut),
    .ctl(ctl), .laneEn(laneEn)
  );

  vsix_datapath #(.LANES(LANES)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .laneEn(laneEn),
    .inRow(inRow), .outRow(outRow)
  );

  // R7: a stalled row keeps its data
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outRow));
endmodule

// File: tb/tb_vsix_interp.sv
module tb_vsix_interp;
  localparam int LANES = 16;

  logic             clk = 0;
  logic             rstN = 0;
  logic             startIn = 0;
  logic [1:0]       widthSel = 0;
  logic [1:0]       heightSel = 0;
  logic             inValid = 0;
  logic             inReady;
  logic [LANES*8-1:0] inRow = '0;
  logic             outValid;
  logic             outReady = 0;
  logic [LANES*8-1:0] outRow;
  logic             doneOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] src [0:20][0:LANES-1];

  always #2 clk = ~clk;  // 250 MHz

  vsix_interp dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog: actual=hung expected=finish");
      bad = bad + 1;
      total = total + 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] refPix(int r, int l);
    int s;
    int v;
    s = (src[r][l] + src[r+5][l]) + 20 * (src[r+2][l] + src[r+3][l])
        - 5 * (src[r+1][l] + src[r+4][l]);
    v = (s + 16) >>> 5;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v[7:0];
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode 0 random, 1 clamp pattern, 2 flat value
  task automatic fillSrc(int mode);
    for (int r = 0; r < 21; r++)
      for (int l = 0; l < LANES; l++)
        case (mode)
          0: src[r][l] = 8'($urandom);
          1: src[r][l] = (((r + l) % 4) < 2) ? 8'd255 : 8'd0;
          default: src[r][l] = 8'(37 + 11 * l);
        endcase
  endtask

  task automatic runBlock(string name, int wcode, int hcode, int mode, bit stall);
    int lanes;
    int rows;
    int inIdx;
    int outIdx;
    int iter;
    int lastFire;
    bit prevHeld;
    bit earlyBad;
    bit holdBad;
    bit doneBad;
    logic [LANES*8-1:0] prevRow;
    logic [LANES*8-1:0] exp;
    lanes = (wcode == 0) ? 4 : (wcode == 1) ? 8 : 16;
    rows  = (hcode == 0) ? 4 : (hcode == 1) ? 8 : 16;
    fillSrc(mode);
    @(negedge clk);
    startIn = 1; widthSel = 2'(wcode); heightSel = 2'(hcode);
    @(negedge clk);
    startIn = 0;
    inIdx = 0; outIdx = 0; iter = 0; lastFire = -10;
    prevHeld = 0; earlyBad = 0; holdBad = 0; doneBad = 0; prevRow = '0;
    while ((outIdx < rows || iter <= lastFire + 2) && iter < 3000) begin
      // R4: nothing offered before six rows are in
      if (outValid && inIdx < 6) earlyBad = 1;
      // R7: previous stall must leave row in place
      if (prevHeld && (!outValid || outRow != prevRow)) holdBad = 1;
      // R8: done exactly one cycle after final handshake
      if (doneOut != (iter == lastFire + 1)) doneBad = 1;
      outReady = stall ? (($urandom % 3) != 0) : 1'b1;
      inValid  = (inIdx < rows + 5) && (($urandom % 4) != 0);
      for (int l = 0; l < LANES; l++) inRow[l*8 +: 8] = src[(inIdx < 21) ? inIdx : 20][l];
      #1;
      prevHeld = outValid && !outReady;
      prevRow  = outRow;
      if (outValid && outReady) begin
        exp = '0;
        for (int l = 0; l < lanes; l++) exp[l*8 +: 8] = refPix(outIdx, l);
        // R1 R2 R3 R5: filtered value per lane, zero above active lanes
        check(outRow == exp, $sformatf("R1/R5 %s row %0d", name, outIdx), outRow, exp);
        if (outIdx == rows - 1) lastFire = iter;
        outIdx++;
      end
      if (inValid && inReady) inIdx++;
      @(negedge clk);
      iter++;
    end
    outReady = 0;
    check(iter < 3000, {"R6 ", name, " completion"}, 128'(outIdx), 128'(rows));
    check(!earlyBad, {"R4 ", name, " early output"}, 128'(earlyBad), 0);
    check(!holdBad, {"R7 ", name, " stall hold"}, 128'(holdBad), 0);
    check(!doneBad, {"R8 ", name, " done pulse"}, 128'(doneBad), 0);
    // R6: extra rows refused after the block
    inValid = 1;
    #1;
    check(!inReady && inIdx == rows + 5, {"R6 ", name, " row count"},
          128'(inIdx), 128'(rows + 5));
    @(negedge clk);
    check(!inReady && !outValid, {"R6 ", name, " idle after block"},
          128'({inReady, outValid}), 0);
    inValid = 0;
  endtask

  task automatic testReset;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9: all handshake outputs low before any start
    check(!inReady && !outValid && !doneOut, "R9 reset state",
          128'({inReady, outValid, doneOut}), 0);
  endtask

  initial begin
    testReset();
    runBlock("w16h4rand", 2, 0, 0, 0);
    runBlock("w8h8clamp", 1, 1, 1, 1);
    runBlock("w4h16rand", 0, 2, 0, 1);
    runBlock("w16h16clamp", 3, 3, 1, 1);
    runBlock("w8h4flat", 1, 0, 2, 0);
    runBlock("w16h8rand", 2, 1, 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule